// File: doc/BRIEF.md
# Paged External-Data RAM

This block is a 1024-byte data RAM that sits on a small microcontroller's external-data bus. The processor reaches it in one of two ways. A long access carries a full 16-bit address. A short access carries only an 8-bit offset, and the two upper RAM address bits come from a page register that software writes. In both modes the RAM repeats every 1 KB across the whole 64K space. Because of this, a pointer that keeps counting past the top of the RAM lands back on byte 0.

The page register sits on the special-function-register (SFR) bus at address 0xAF. Only its two low bits hold state. The other six bits read as zero. RAM writes take effect on the clock edge where the write strobe is high. Read data, for both the RAM and the page register, is registered and arrives one clock after the read strobe, together with a valid flag. The RAM has no reset, so its contents are undefined after reset. Only the page register has a reset value.

Top module: `paged_xram`

## Requirements
- R1: A long write (`mem_short`=0) stores `mem_wdata` on the clock edge where `mem_wr` is high. A later long read of the same address returns that byte on `mem_rdata`, with `mem_rvalid` high, in the cycle after the edge that sampled `mem_rd`. `mem_rvalid` is low after any edge where `mem_rd` was low.
- R2: Address bits 15:10 never affect which byte is reached. In short mode, bits 15:8 are also ignored. For example, 0x0000, 0x0400 and 0xFC00 all reach the same byte.
- R3: A long access uses `mem_addr[9:0]` as the RAM address and ignores the page register.
- R4: A short access (`mem_short`=1) uses RAM address {page[1:0], mem_addr[7:0]}. Page 0 covers 0x000–0x0FF, page 1 covers 0x100–0x1FF, page 2 covers 0x200–0x2FF and page 3 covers 0x300–0x3FF.
- R5: The page register answers at SFR address 0xAF. A write there sets bits 1:0 from `sfr_wdata[1:0]` and discards bits 7:2. A read there returns {000000, page} on `sfr_rdata`, with `sfr_rvalid` high, one clock after the edge that sampled `sfr_rd`.
- R6: While `rst` is high at a clock edge, the page register is cleared to 0 and `mem_rvalid`, `sfr_rvalid` and `sfr_rdata` are cleared to 0.
- R7: Consecutive long writes from 0x03FE through 0x0401 wrap. The bytes written at 0x0400 and 0x0401 are found at RAM bytes 0 and 1.
- R8: An SFR read or write at any address other than 0xAF leaves the page register unchanged. It also leaves `sfr_rvalid` low and `sfr_rdata` at 0x00 in the following cycle.
- R9: If a page write and a short access occur in the same cycle, the access uses the page value from before the write. The new page applies from the next cycle.
- R10: If a read and a write hit the same address in the same cycle, `mem_rdata` returns the byte held before the write, and the write still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | input | 1 | RAM read strobe |
| mem_wr | input | 1 | RAM write strobe |
| mem_short | input | 1 | 1 = 8-bit offset plus page register, 0 = full 16-bit address |
| mem_addr | input | 16 | External-data address |
| mem_wdata | input | 8 | RAM write data |
| mem_rdata | output | 8 | Registered RAM read data |
| mem_rvalid | output | 1 | High one cycle after a sampled read |
| sfr_addr | input | 8 | SFR bus address |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Registered SFR read data, 0x00 when the page register is not read |
| sfr_rvalid | output | 1 | High one cycle after a sampled read at 0xAF |

## Verification
Every result is due exactly one register stage after the edge that samples its stimulus. A RAM write or page write changes state at that edge. RAM read data, SFR read data and both valid flags appear right after that same edge. The bench drives inputs on the falling edge and advances a reference model at the rising edge, using the inputs held across that edge. It compares all outputs on the next falling edge, so every check falls in the cycle where its result is due. The same-cycle cases (read with write, page write with short access) follow from the model's rule: it reads old state before it applies the edge's updates.

// File: rtl/xram_pkg.sv
package xram_pkg;

  // Default geometry of the paged RAM
  localparam int unsigned XRAM_BUS_AW   = 16;
  localparam int unsigned XRAM_RAM_AW   = 10;
  localparam int unsigned XRAM_SHORT_AW = 8;
  localparam int unsigned XRAM_DW       = 8;
  localparam int unsigned XRAM_SFR_AW   = 8;
  localparam logic [7:0]  XRAM_PAGE_SFR = 8'hAF;

  // How an external-data access forms its RAM address
  typedef enum logic {
    ADDR_LONG  = 1'b0,
    ADDR_SHORT = 1'b1
  } addr_mode_e;

endpackage

// File: rtl/xram_addr_gen.sv
module xram_addr_gen #(
  parameter int unsigned BUS_AW   = 16,
  parameter int unsigned RAM_AW   = 10,
  parameter int unsigned SHORT_AW = 8,
  localparam int unsigned PAGE_W  = RAM_AW - SHORT_AW
) (
  input  xram_pkg::addr_mode_e mode,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [PAGE_W-1:0]    page,
  output logic [RAM_AW-1:0]    ram_addr
);

  // Bits above the RAM size alias the array; they select nothing.
  logic unused_alias_bits;
  assign unused_alias_bits = ^bus_addr[BUS_AW-1:RAM_AW];

  logic [RAM_AW-1:0] long_addr;
  logic [RAM_AW-1:0] short_addr;

  assign long_addr  = bus_addr[RAM_AW-1:0];
  assign short_addr = {page, bus_addr[SHORT_AW-1:0]};

  always_comb begin
    unique case (mode)
      xram_pkg::ADDR_SHORT: ram_addr = short_addr;
      default:              ram_addr = long_addr;
    endcase
  end

endmodule

// File: rtl/xram_page_reg.sv
module xram_page_reg #(
  parameter int unsigned     SFR_AW   = 8,
  parameter int unsigned     DW       = 8,
  parameter int unsigned     PAGE_W   = 2,
  parameter logic [SFR_AW-1:0] REG_ADDR = 8'hAF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_rd,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic [DW-1:0]     sfr_rdata,
  output logic              sfr_rvalid
);

  localparam int unsigned PAD_W = DW - PAGE_W;

  logic hit;
  logic unused_wdata_hi;

  assign hit             = (sfr_addr == REG_ADDR);
  assign unused_wdata_hi = ^sfr_wdata[DW-1:PAGE_W];

  // Page state: only the low bits are stored
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (sfr_wr && hit) begin
      page_q <= sfr_wdata[PAGE_W-1:0];
    end
  end

  // Registered read port; returns the pre-write value
  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rdata  <= '0;
      sfr_rvalid <= 1'b0;
    end else begin
      sfr_rvalid <= sfr_rd && hit;
      sfr_rdata  <= (sfr_rd && hit) ? {{PAD_W{1'b0}}, page_q} : '0;
    end
  end

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    sfr_rdata[DW-1:PAGE_W] == '0);

  a_r5_page_write: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr && hit) |=> page_q == $past(sfr_wdata[PAGE_W-1:0]));

  a_r6_page_reset: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (page_q == '0 && !sfr_rvalid));

  a_r8_page_hold: assert property (@(posedge clk) disable iff (rst)
    !(sfr_wr && hit) |=> $stable(page_q));

  a_r8_no_drive: assert property (@(posedge clk) disable iff (rst)
    !(sfr_rd && hit) |=> (!sfr_rvalid && sfr_rdata == '0));

endmodule

// File: rtl/xram_store.sv
module xram_store #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] mem [DEPTH];

  // Write port: no reset on the array
  always_ff @(posedge clk) begin
    if (wr) begin
      mem[addr] <= wdata;
    end
  end

  // Read-first registered read port with enable
  always_ff @(posedge clk) begin
    if (rd) begin
      rdata <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
    end
  end

  a_r1_rvalid: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  a_r1_no_rvalid: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);

endmodule

// File: rtl/paged_xram.sv
module paged_xram #(
  parameter int unsigned BUS_AW   = xram_pkg::XRAM_BUS_AW,
  parameter int unsigned RAM_AW   = xram_pkg::XRAM_RAM_AW,
  parameter int unsigned SHORT_AW = xram_pkg::XRAM_SHORT_AW,
  parameter int unsigned DW       = xram_pkg::XRAM_DW,
  parameter int unsigned SFR_AW   = xram_pkg::XRAM_SFR_AW,
  parameter logic [SFR_AW-1:0] PAGE_SFR = xram_pkg::XRAM_PAGE_SFR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              mem_short,
  input  logic [BUS_AW-1:0] mem_addr,
  input  logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     mem_rdata,
  output logic              mem_rvalid,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_rd,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  output logic              sfr_rvalid
);

  localparam int unsigned PAGE_W = RAM_AW - SHORT_AW;

  xram_pkg::addr_mode_e mode;
  logic [PAGE_W-1:0]    page_q;
  logic [RAM_AW-1:0]    ram_addr;

  assign mode = mem_short ? xram_pkg::ADDR_SHORT : xram_pkg::ADDR_LONG;

  xram_page_reg #(
    .SFR_AW   (SFR_AW),
    .DW       (DW),
    .PAGE_W   (PAGE_W),
    .REG_ADDR (PAGE_SFR)
  ) u_page (
    .clk        (clk),
    .rst        (rst),
    .sfr_addr   (sfr_addr),
    .sfr_rd     (sfr_rd),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .page_q     (page_q),
    .sfr_rdata  (sfr_rdata),
    .sfr_rvalid (sfr_rvalid)
  );

  xram_addr_gen #(
    .BUS_AW   (BUS_AW),
    .RAM_AW   (RAM_AW),
    .SHORT_AW (SHORT_AW)
  ) u_addr (
    .mode     (mode),
    .bus_addr (mem_addr),
    .page     (page_q),
    .ram_addr (ram_addr)
  );

  xram_store #(
    .AW (RAM_AW),
    .DW (DW)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .rd     (mem_rd),
    .wr     (mem_wr),
    .addr   (ram_addr),
    .wdata  (mem_wdata),
    .rdata  (mem_rdata),
    .rvalid (mem_rvalid)
  );

  a_r4_short_page: assert property (@(posedge clk) disable iff (rst)
    (mem_short && (mem_rd || mem_wr)) |->
      (ram_addr[RAM_AW-1:SHORT_AW] == page_q &&
       ram_addr[SHORT_AW-1:0] == mem_addr[SHORT_AW-1:0]));

  a_r3_long_direct: assert property (@(posedge clk) disable iff (rst)
    (!mem_short && (mem_rd || mem_wr)) |-> ram_addr == mem_addr[RAM_AW-1:0]);

endmodule

// File: tb/sim_paged_xram.sv
`timescale 1ns/1ps
module sim_paged_xram;

  localparam time CLK_HALF = 2.5ns;
  localparam int  WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd = 0, mem_wr = 0, mem_short = 0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        mem_rvalid;
  logic [7:0]  sfr_addr = '0;
  logic        sfr_rd = 0, sfr_wr = 0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        sfr_rvalid;

  always #(CLK_HALF) clk = ~clk;

  paged_xram u0 (
    .clk(clk), .rst(rst),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_short(mem_short),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_rvalid(sfr_rvalid)
  );

  // Reference model state
  logic [7:0] ref_mem [1024];
  bit         known   [1024];
  int         ref_page = 0;
  logic [7:0] exp_rdata = '0;
  bit         exp_rvalid = 0, exp_known = 0, exp_srvalid = 0, started = 0;
  logic [7:0] exp_srdata = '0;
  string      tag = "R6";
  int         checks = 0, fails = 0;
  bit         done = 0;

  initial for (int i = 0; i < 1024; i++) known[i] = 0;

  always @(posedge clk) begin
    int eff;
    started = 1;
    eff = mem_short ? (ref_page * 256 + int'(mem_addr[7:0])) : int'(mem_addr % 16'h0400);
    if (rst) begin
      ref_page    = 0;
      exp_rvalid  = 0;
      exp_srvalid = 0;
      exp_srdata  = 8'h00;
    end else begin
      exp_rvalid = mem_rd;
      if (mem_rd) begin
        exp_known = known[eff];
        exp_rdata = ref_mem[eff];
      end
      if (mem_wr) begin
        ref_mem[eff] = mem_wdata;
        known[eff]   = 1;
      end
      exp_srvalid = sfr_rd && sfr_addr == 8'hAF;
      exp_srdata  = exp_srvalid ? 8'(ref_page) : 8'h00;
      if (sfr_wr && sfr_addr == 8'hAF) ref_page = int'(sfr_wdata[1:0]);
    end
  end

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    check("mem_rvalid", {7'b0, mem_rvalid}, {7'b0, exp_rvalid});
    if (exp_rvalid && exp_known) check("mem_rdata", mem_rdata, exp_rdata);
    check("sfr_rvalid", {7'b0, sfr_rvalid}, {7'b0, exp_srvalid});
    check("sfr_rdata", sfr_rdata, exp_srdata);
  end

  task automatic mop(input logic rd, input logic wr, input logic sh,
                     input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    mem_rd = rd; mem_wr = wr; mem_short = sh; mem_addr = a; mem_wdata = d;
    sfr_rd = 0; sfr_wr = 0;
  endtask

  task automatic sop(input logic rd, input logic wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    mem_rd = 0; mem_wr = 0;
    sfr_rd = rd; sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    mem_rd = 0; mem_wr = 0; sfr_rd = 0; sfr_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R6";
    sop(1, 0, 8'hAF, 0);   // read issued during reset: still cleared
    @(negedge clk);
    rst = 0;
    sop(1, 0, 8'hAF, 0);   // page reads 0 after reset
    idle();

    tag = "R1";
    mop(0, 1, 0, 16'h0012, 8'h5A);
    mop(0, 1, 0, 16'h03FF, 8'hC3);
    mop(1, 0, 0, 16'h0012, 0);
    mop(1, 0, 0, 16'h03FF, 0);
    idle();

    tag = "R2";
    mop(0, 1, 0, 16'h0477, 8'h91);
    mop(1, 0, 0, 16'h0077, 0);
    mop(1, 0, 0, 16'hFC77, 0);
    mop(1, 0, 1, 16'hAB77, 0);     // short, page 0, high byte junk
    idle();

    tag = "R5";
    sop(0, 1, 8'hAF, 8'hFF);
    sop(1, 0, 8'hAF, 0);           // reads 0x03
    sop(0, 1, 8'hAF, 8'hFC);
    sop(1, 0, 8'hAF, 0);           // reads 0x00

    tag = "R4";
    for (int p = 0; p < 4; p++) begin
      sop(0, 1, 8'hAF, 8'(p));
      mop(0, 1, 1, {8'h3C, 8'h55}, 8'(8'h10 + p));
      mop(1, 0, 0, 16'(p * 256 + 16'h0055), 0);
      mop(1, 0, 1, {8'hE1, 8'h55}, 0);
    end
    idle();

    tag = "R3";
    sop(0, 1, 8'hAF, 8'h02);
    mop(0, 1, 0, 16'h0133, 8'h6E);   // long ignores page 2
    sop(0, 1, 8'hAF, 8'h01);
    mop(1, 0, 1, 16'h0033, 0);       // short page 1 sees it
    mop(1, 0, 0, 16'h0133, 0);
    idle();

    tag = "R8";
    sop(0, 1, 8'hAE, 8'h03);
    sop(0, 1, 8'hB0, 8'h02);
    sop(1, 0, 8'hAE, 0);
    sop(1, 0, 8'h2F, 0);
    sop(1, 0, 8'hAF, 0);             // still 0x01
    idle();

    tag = "R7";
    for (int i = 0; i < 4; i++) mop(0, 1, 0, 16'(16'h03FE + i), 8'(8'hA0 + i));
    mop(1, 0, 0, 16'h0000, 0);
    mop(1, 0, 0, 16'h0001, 0);
    mop(1, 0, 0, 16'h03FE, 0);
    idle();

    tag = "R9";
    sop(0, 1, 8'hAF, 8'h00);
    @(negedge clk);                  // page write and short write together
    mem_wr = 1; mem_rd = 0; mem_short = 1; mem_addr = 16'h0044; mem_wdata = 8'h7D;
    sfr_wr = 1; sfr_rd = 1; sfr_addr = 8'hAF; sfr_wdata = 8'h03;
    mop(1, 0, 0, 16'h0044, 0);       // landed in page 0
    mop(1, 0, 1, 16'h0044, 0);       // now page 3
    mop(0, 1, 1, 16'h0044, 8'h3E);
    mop(1, 0, 0, 16'h0344, 0);
    idle();

    tag = "R10";
    mop(0, 1, 0, 16'h0200, 8'h11);
    mop(1, 1, 0, 16'h0200, 8'h22);   // returns 0x11
    mop(1, 0, 0, 16'h0600, 0);       // returns 0x22
    idle();
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL %s watchdog: actual %0d expected %0d", tag, 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule